// File: doc/BRIEF.md
# Keyboard, Border and Speaker I/O Port

This block is the single I/O port of a small home-computer style system. It watches the processor's I/O address and strobes, decoding nothing but address bit 0: any port number with that bit clear is the port. A write to it latches a three-bit border colour, a tape output bit and a one-bit speaker output. A read from it returns one scan of a 40-key matrix, organised as eight half-rows of five keys, together with the tape input level.

The half-row to scan is chosen by the upper address byte. Each of its eight bits enables one half-row when it is driven low. When several bits are low, the key lines of all enabled half-rows are combined with an active-low wired-AND. Reads from any port with address bit 0 set return the most recent byte the display fetcher took from memory while a fetch period is under way, and 0xFF at all other times. A parameter turns this floating-bus behaviour off, so that odd ports always read 0xFF.

Top module: `kbd_border_port`

## Requirements
- R1: The port is selected when addr[0] is 0; addr[7:1] have no effect on reads or writes.
- R2: On the clock edge where io_wr is high and addr[0] is 0, border takes wdata[2:0], mic_out takes wdata[3] and spk_out takes wdata[4]; wdata[7:5] are ignored and writes with addr[0] = 1 change nothing.
- R3: During and after a synchronous active-low reset, border, mic_out and spk_out are 0 and the stored fetch byte is 0xFF.
- R4: A read (io_rd high) with addr[0] = 0 returns in rdata[c] the key line keys_n[r*5+c] (0 = pressed) of half-row r, where half-row r is enabled by addr[8+r] = 0.
- R5: With several half-rows enabled, rdata[4:0] is the bitwise AND of their key lines; with none enabled, rdata[4:0] is 5'b11111.
- R6: On an even-port read, rdata[6] equals ear_in and rdata[7] and rdata[5] are 1.
- R7: With floating bus enabled, a read with addr[0] = 1 returns the fetch_data value captured at the last edge where fetch_stb was high while fetch_period is high, and 0xFF while fetch_period is low.
- R8: With floating bus disabled (FLOAT_EN = 0), every read with addr[0] = 1 returns 0xFF.
- R9: While io_rd is low, rdata is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | I/O address; bit 0 selects, bits 15:8 enable half-rows |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0xFF when not reading |
| keys_n | input | 40 | Key matrix, active low, index row*5+column |
| ear_in | input | 1 | Tape input level |
| fetch_stb | input | 1 | Display fetcher has a byte on the bus this cycle |
| fetch_data | input | 8 | Byte taken by the display fetcher |
| fetch_period | input | 1 | High while display fetching is in progress |
| border | output | 3 | Border colour |
| mic_out | output | 1 | Tape output bit |
| spk_out | output | 1 | Speaker bit |

## Verification
The bench builds two copies side by side: one with floating-bus support on, which brings the fetch capture, the fetch-period gating and the odd-port return path within reach, and one with FLOAT_EN = 0, which exercises the variant where odd ports are constant 0xFF. Both use the default eight half-rows of five keys, so every enable bit of the upper address byte and every multi-row wired-AND combination can be driven, including the all-enabled and none-enabled cases.

// File: rtl/kbd_port_pkg.sv
// Shared constants and types for the keyboard/border/speaker port.
// Assumes an 8-bit data bus and a three-bit colour field.
package kbd_port_pkg;
    localparam int DATA_W   = 8;
    localparam int COLOR_W  = 3;
    localparam int MIC_BIT  = 3;
    localparam int SPK_BIT  = 4;
    localparam int EAR_BIT  = 6;

    typedef struct packed {
        logic               spk;
        logic               mic;
        logic [COLOR_W-1:0] border;
    } out_latch_t;
endpackage

// File: rtl/kbd_row_merge.sv
// Combines the key lines of every enabled half-row with an active-low
// wired-AND. Assumes row_sel_n bit r enables half-row r when low and
// keys_n holds half-row r in bits [r*COLS +: COLS]. Purely combinational.
module kbd_row_merge #(
    parameter int ROWS = 8,
    parameter int COLS = 5
) (
    input  logic [ROWS-1:0]      row_sel_n,
    input  logic [ROWS*COLS-1:0] keys_n,
    output logic [COLS-1:0]      cols_n
);
    logic [COLS-1:0] masked [ROWS];

    // Force a disabled half-row to all ones so it drops out of the AND.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign masked[r] = keys_n[r*COLS +: COLS] | {COLS{row_sel_n[r]}};
    end

    // Fold all half-rows together.
    always_comb begin
        cols_n = '1;
        for (int r = 0; r < ROWS; r++) begin
            cols_n = cols_n & masked[r];
        end
    end
endmodule

// File: rtl/port_write_regs.sv
// Output latches for border colour, tape output and speaker. Assumes
// wr_en is already qualified by the port decode. Synchronous active-low reset.
module port_write_regs
    import kbd_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SPK_BIT:0]  wbits,
    output out_latch_t        q
);
    // Capture the low five data bits on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q.border <= wbits[COLOR_W-1:0];
            q.mic    <= wbits[MIC_BIT];
            q.spk    <= wbits[SPK_BIT];
        end
    end

    // R2
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == {$past(wbits[SPK_BIT]), $past(wbits[MIC_BIT]),
                         $past(wbits[COLOR_W-1:0])}));

    // R2
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

    // R3
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
endmodule

// File: rtl/float_bus_latch.sv
// Holds the last byte the display fetcher took from the bus. Assumes
// fetch_stb marks a valid fetch_data. Synchronous active-low reset to 0xFF.
module float_bus_latch
    import kbd_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_stb,
    input  logic [DATA_W-1:0] fetch_data,
    output logic [DATA_W-1:0] q
);
    // Record each fetched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '1;
        end else if (fetch_stb) begin
            q <= fetch_data;
        end
    end

    // R7
    fetch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |=> (q == $past(fetch_data)));

    // R7
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_stb |=> $stable(q));
endmodule

// File: rtl/kbd_border_port.sv
// Partially decoded I/O port: address bit 0 low selects it. Writes set
// border, tape output and speaker; reads return a keyboard scan and the
// tape input; odd-port reads return the floating video bus when enabled.
// Assumes COLS <= 5 so key lines fit below the fixed bit 5.
module kbd_border_port
    import kbd_port_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int COLS     = 5,
    parameter bit FLOAT_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [8+ROWS-1:0]     addr,
    input  logic                  io_rd,
    input  logic                  io_wr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [ROWS*COLS-1:0]  keys_n,
    input  logic                  ear_in,
    input  logic                  fetch_stb,
    input  logic [DATA_W-1:0]     fetch_data,
    input  logic                  fetch_period,
    output logic [COLOR_W-1:0]    border,
    output logic                  mic_out,
    output logic                  spk_out
);
    localparam int ADDR_W = 8 + ROWS;

    logic              port_sel;
    logic [COLS-1:0]   cols_n;
    logic [DATA_W-1:0] even_byte;
    logic [DATA_W-1:0] odd_byte;
    out_latch_t        latch_q;
    logic              unused_bits;

    // Only bit 0 takes part in the decode; the rest of the low byte is spare.
    assign port_sel    = ~addr[0];
    assign unused_bits = ^{addr[7:1], wdata[DATA_W-1:SPK_BIT+1]};

    kbd_row_merge #(.ROWS(ROWS), .COLS(COLS)) i_merge (
        .row_sel_n (addr[ADDR_W-1:8]),
        .keys_n    (keys_n),
        .cols_n    (cols_n)
    );

    port_write_regs i_wregs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (io_wr && port_sel),
        .wbits (wdata[SPK_BIT:0]),
        .q     (latch_q)
    );

    assign border  = latch_q.border;
    assign mic_out = latch_q.mic;
    assign spk_out = latch_q.spk;

    // Assemble the even-port read byte: ones, tape input, key lines.
    always_comb begin
        even_byte          = '1;
        even_byte[COLS-1:0] = cols_n;
        even_byte[EAR_BIT] = ear_in;
    end

    // Select the floating-bus variant.
    if (FLOAT_EN) begin : g_float
        logic [DATA_W-1:0] fetched_q;
        float_bus_latch i_float (
            .clk        (clk),
            .rst_n      (rst_n),
            .fetch_stb  (fetch_stb),
            .fetch_data (fetch_data),
            .q          (fetched_q)
        );
        assign odd_byte = fetch_period ? fetched_q : '1;
    end else begin : g_nofloat
        logic unused_fetch;
        assign unused_fetch = ^{fetch_stb, fetch_data, fetch_period};
        assign odd_byte     = '1;
    end

    // Read data multiplexer.
    always_comb begin
        if (!io_rd)        rdata = '1;
        else if (port_sel) rdata = even_byte;
        else               rdata = odd_byte;
    end

    // R6
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !addr[0]) |-> (rdata[7] && rdata[5] && rdata[6] == ear_in));

    // R5
    no_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !addr[0] && (&addr[ADDR_W-1:8])) |-> (&rdata[COLS-1:0]));

    // R7
    outside_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && addr[0] && !fetch_period) |-> (rdata == 8'hFF));

    // R8
    float_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!FLOAT_EN && io_rd && addr[0]) |-> (rdata == 8'hFF));

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (rdata == 8'hFF));

    // R2
    odd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr[0]) |=> $stable({border, mic_out, spk_out}));
endmodule

// File: tb/test_kbd_border_port.sv
// Bench: random port traffic with directed corners, compared against
// a model built from the requirements. Two copies: floating bus on/off.
module test_kbd_border_port;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'hFFFF;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [39:0] keys_n = '1;
    logic        ear_in = 1'b0;
    logic        fetch_stb = 1'b0;
    logic [7:0]  fetch_data = '0;
    logic        fetch_period = 1'b0;
    logic [7:0]  rdata, rdata_nf;
    logic [2:0]  border, border_nf;
    logic        mic_out, spk_out, mic_nf, spk_nf;

    int checks = 0, errors = 0;
    logic [2:0] m_border;
    logic       m_mic, m_spk;
    logic [7:0] m_fetch;

    always #(PERIOD/2) clk = ~clk;

    kbd_border_port #(.FLOAT_EN(1'b1)) i_kbd_border_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_rd(io_rd), .io_wr(io_wr),
        .wdata(wdata), .rdata(rdata), .keys_n(keys_n), .ear_in(ear_in),
        .fetch_stb(fetch_stb), .fetch_data(fetch_data),
        .fetch_period(fetch_period), .border(border), .mic_out(mic_out),
        .spk_out(spk_out));

    kbd_border_port #(.FLOAT_EN(1'b0)) i_kbd_border_port_nf (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_rd(io_rd), .io_wr(io_wr),
        .wdata(wdata), .rdata(rdata_nf), .keys_n(keys_n), .ear_in(ear_in),
        .fetch_stb(fetch_stb), .fetch_data(fetch_data),
        .fetch_period(fetch_period), .border(border_nf), .mic_out(mic_nf),
        .spk_out(spk_nf));

    function automatic logic [4:0] exp_keys(logic [15:0] a, logic [39:0] k);
        logic [4:0] c = 5'b11111;
        for (int r = 0; r < 8; r++) if (!a[8+r]) c &= k[r*5 +: 5];
        return c;
    endfunction

    function automatic logic [7:0] exp_read(bit fl_en);
        if (!io_rd) return 8'hFF;
        if (!addr[0]) return {1'b1, ear_in, 1'b1, exp_keys(addr, keys_n)};
        if (fl_en && fetch_period) return m_fetch;
        return 8'hFF;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic chk_outs(string tag);
        chk(tag, {3'b0, spk_out, mic_out, border}, {3'b0, m_spk, m_mic, m_border});
        chk(tag, {3'b0, spk_nf, mic_nf, border_nf}, {3'b0, m_spk, m_mic, m_border});
    endtask

    // One bus cycle: drive at negedge, check reads, update model at posedge.
    task automatic cycle(string tag);
        #1;
        chk(tag, rdata, exp_read(1'b1));
        chk(tag, rdata_nf, exp_read(1'b0));
        @(posedge clk);
        if (io_wr && !addr[0]) begin
            m_border = wdata[2:0]; m_mic = wdata[3]; m_spk = wdata[4];
        end
        if (fetch_stb) m_fetch = fetch_data;
        @(negedge clk);
        chk_outs(tag);
    endtask

    task automatic idle();
        io_rd = 0; io_wr = 0; fetch_stb = 0;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        m_border = '0; m_mic = 0; m_spk = 0; m_fetch = 8'hFF;
        repeat (3) @(negedge clk);
        chk_outs("R3 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // R3: stored fetch byte is 0xFF after reset
        io_rd = 1; addr = 16'h00FF; fetch_period = 1; cycle("R3 fetch reset");

        // R1 R2: even write with odd-looking low bits, upper data bits set
        idle(); io_wr = 1; addr = 16'h12FE; wdata = 8'hFF; cycle("R2 write all");
        io_wr = 1; addr = 16'h0080; wdata = 8'hEA; cycle("R1 write low bits ignored");
        // R2: odd write leaves latches alone
        io_wr = 1; addr = 16'h0001; wdata = 8'h1F; cycle("R2 odd write ignored");

        // R4: Z (row 0 column 1) pressed, high byte 0xFE
        idle(); io_rd = 1; keys_n = '1; keys_n[1] = 0; ear_in = 1;
        addr = 16'hFEFE; cycle("R4 row0 key");
        addr = 16'h7F7E; keys_n = '1; keys_n[35] = 0; ear_in = 0; cycle("R4 row7 key");
        // R5: all rows and no rows
        keys_n = 40'hFF_FFFF_FFFF ^ 40'h84_2108_4210; addr = 16'h0000; cycle("R5 all rows");
        addr = 16'hFFFE; cycle("R5 no row");
        // R6: fixed bits with ear both ways
        addr = 16'hBFFE; ear_in = 1; cycle("R6 ear high");
        // R7: capture then read in and out of fetch period
        fetch_stb = 1; fetch_data = 8'h5A; io_rd = 0; cycle("R7 capture");
        fetch_stb = 0; io_rd = 1; addr = 16'h00FF; fetch_period = 1; cycle("R7 odd in period");
        fetch_period = 0; cycle("R7 odd outside period");
        // R8 is covered by the second copy on every odd read above
        fetch_period = 1; cycle("R8 odd float off");
        // R9
        io_rd = 0; addr = 16'h00FE; cycle("R9 idle read");

        // Random traffic
        for (int i = 0; i < 2000; i++) begin
            addr = 16'($urandom); wdata = 8'($urandom);
            keys_n = {8'($urandom), 32'($urandom)};
            ear_in = 1'($urandom); io_rd = 1'($urandom);
            io_wr = ($urandom % 3) == 0; fetch_stb = 1'($urandom);
            fetch_data = 8'($urandom); fetch_period = ($urandom % 4) != 0;
            if (addr[0]) cycle("R7 R8 random odd");
            else if (io_wr) cycle("R2 random write");
            else cycle("R4 R5 random read");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule